// File: doc/BRIEF.md
# Light-Load Skip and Setpoint Soft-Start Controller

This block sits between a filtered feedback path and the peak-current comparator of a switching converter. It receives an unsigned code for the requested peak-current setpoint. It produces two outputs. The first is a pulse-allow flag that stops switching when the load is light. The second is an effective setpoint code that is limited by a soft-start ramp.

Under light load the request falls to a low threshold and pulses stop. They resume only once the request climbs past a higher threshold. This wide hysteresis keeps the converter in a slow burst pattern instead of chattering at one level. Every resume starts a fresh, short setpoint ramp from zero. A power-up, or a restart ordered by the protection logic, uses a much slower ramp instead. Once the ramp is complete, the request passes straight through.

Both ramp rates are clock-cycle prescaler values. With a 16 MHz clock, the defaults give about 4 ms and about 300 us for a full-scale ramp.

Top module: `skip_ss_ctrl`

## Requirements
In these requirements, FULL is 2^SP_W-1. ENTER is floor(FULL*20/100) and EXIT is floor(FULL*25/100).

- R1: While rst_ni is low, and directly after it, pulse_en_o is 1 and sp_o is 0. The ramp starts at zero at the slow (cold) rate.
- R2: If pulses are allowed and req_sp_i <= ENTER before a clock edge, pulse_en_o is 0 after that edge. A request above ENTER keeps pulses allowed.
- R3: If pulses are stopped and req_sp_i >= EXIT before a clock edge, pulse_en_o is 1 after that edge. A request below EXIT keeps pulses stopped.
- R4: While pulse_en_o is 0, sp_o is 0 and the ramp is held at zero.
- R5: While pulse_en_o is 1, sp_o equals the lesser of req_sp_i and the ramp value, combinationally in req_sp_i.
- R6: After reset release, the ramp equals floor(n/COLD_DIV), capped at FULL, n edges later.
- R7: After a resume with no restart since the last stop, the ramp is 0 at the resume edge. It then rises by one every WARM_DIV edges.
- R8: restart_i high at an edge clears the ramp at that edge and selects the cold rate. This holds even when it coincides with a stop or falls within a stop period. The next ramp then rises by one every COLD_DIV edges.
- R9: Once the ramp reaches FULL it stays there, and sp_o equals req_sp_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_sp_i | input | SP_W | Requested peak-current setpoint code |
| restart_i | input | 1 | Protection restart: re-arm the slow ramp |
| pulse_en_o | output | 1 | Switching pulses allowed |
| sp_o | output | SP_W | Effective clamped setpoint code |

## Verification
Two events can land on the same edge: a protection restart and a skip stop. The bench provokes this by raising restart_i in the cycle where the request drops to zero. At that edge the stop logic selects the fast rate while the restart selects the slow one, and the restart must win. The bench judges the outcome by releasing the request and confirming that the following ramp rises at the cold rate. The hysteresis is swept one code per cycle in both directions, and every code is compared against an arithmetic model of the two thresholds.

// File: rtl/skip_ss_pkg.sv
package skip_ss_pkg;
  typedef enum logic {RATE_WARM = 1'b0, RATE_COLD = 1'b1} rate_e;

  function automatic int unsigned pct_code(int unsigned full, int unsigned pct);
    return (full * pct) / 100;
  endfunction
endpackage

// File: rtl/skip_hyst.sv
module skip_hyst #(
  parameter int unsigned SP_W  = 8,
  parameter int unsigned ENTER = 51,
  parameter int unsigned EXIT  = 63
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SP_W-1:0] req_i,
  output logic            stopped_o,
  output logic            stop_set_o
);
  localparam logic [SP_W-1:0] ENTER_V = SP_W'(ENTER);
  localparam logic [SP_W-1:0] EXIT_V  = SP_W'(EXIT);

  logic stopped_q, stopped_d;

  assign stop_set_o = !stopped_q && (req_i <= ENTER_V);

  always_comb begin
    if (stopped_q) stopped_d = (req_i < EXIT_V);
    else           stopped_d = stop_set_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stopped_q <= 1'b0;
    else         stopped_q <= stopped_d;
  end

  assign stopped_o = stopped_q;
endmodule

// File: rtl/ss_rate.sv
module ss_rate
  import skip_ss_pkg::*;
#(
  parameter int unsigned COLD_DIV = 251,
  parameter int unsigned WARM_DIV = 19
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic sat_i,
  input  logic restart_i,
  input  logic stop_set_i,
  output logic tick_o
);
  localparam int unsigned MAXDIV = (COLD_DIV > WARM_DIV) ? COLD_DIV : WARM_DIV;
  localparam int unsigned CNT_W  = $clog2(MAXDIV + 1);
  localparam logic [CNT_W-1:0] COLD_LIM = CNT_W'(COLD_DIV - 1);
  localparam logic [CNT_W-1:0] WARM_LIM = CNT_W'(WARM_DIV - 1);

  rate_e            rate_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // restart has priority over a coincident stop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rate_q <= RATE_COLD;
    else if (restart_i)  rate_q <= RATE_COLD;
    else if (stop_set_i) rate_q <= RATE_WARM;
  end

  generate
    if (COLD_DIV == WARM_DIV) begin : g_one_rate
      assign lim = COLD_LIM;
    end else begin : g_two_rate
      assign lim = (rate_q == RATE_COLD) ? COLD_LIM : WARM_LIM;
    end
  endgenerate

  assign tick_o = !clear_i && !sat_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i || sat_i)  cnt_q <= '0;
    else if (tick_o)            cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ss_ramp.sv
module ss_ramp #(
  parameter int unsigned SP_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            tick_i,
  output logic [SP_W-1:0] ramp_o,
  output logic            sat_o
);
  logic [SP_W-1:0] ramp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ramp_q <= '0;
    else if (clear_i) ramp_q <= '0;
    else if (tick_i)  ramp_q <= ramp_q + 1'b1;
  end

  assign sat_o  = &ramp_q;
  assign ramp_o = ramp_q;
endmodule

// File: rtl/sp_clamp.sv
module sp_clamp #(
  parameter int unsigned SP_W = 8
) (
  input  logic            run_i,
  input  logic [SP_W-1:0] req_i,
  input  logic [SP_W-1:0] ramp_i,
  output logic [SP_W-1:0] sp_o
);
  always_comb begin
    if (!run_i)               sp_o = '0;
    else if (req_i < ramp_i)  sp_o = req_i;
    else                      sp_o = ramp_i;
  end
endmodule

// File: rtl/skip_ss_ctrl.sv
module skip_ss_ctrl
  import skip_ss_pkg::*;
#(
  parameter int unsigned SP_W      = 8,
  parameter int unsigned COLD_DIV  = 251,
  parameter int unsigned WARM_DIV  = 19,
  parameter int unsigned ENTER_PCT = 20,
  parameter int unsigned EXIT_PCT  = 25
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SP_W-1:0] req_sp_i,
  input  logic            restart_i,
  output logic            pulse_en_o,
  output logic [SP_W-1:0] sp_o
);
  localparam int unsigned FULL       = (1 << SP_W) - 1;
  localparam int unsigned ENTER_CODE = pct_code(FULL, ENTER_PCT);
  localparam int unsigned EXIT_CODE  = pct_code(FULL, EXIT_PCT);

  logic            stopped, stop_set, clear, tick, sat;
  logic [SP_W-1:0] ramp_q;

  skip_hyst #(.SP_W(SP_W), .ENTER(ENTER_CODE), .EXIT(EXIT_CODE)) u_hyst (
    .clk_i, .rst_ni, .req_i(req_sp_i), .stopped_o(stopped), .stop_set_o(stop_set)
  );

  assign clear = stopped || restart_i;

  ss_rate #(.COLD_DIV(COLD_DIV), .WARM_DIV(WARM_DIV)) u_rate (
    .clk_i, .rst_ni, .clear_i(clear), .sat_i(sat), .restart_i,
    .stop_set_i(stop_set), .tick_o(tick)
  );

  ss_ramp #(.SP_W(SP_W)) u_ramp (
    .clk_i, .rst_ni, .clear_i(clear), .tick_i(tick), .ramp_o(ramp_q), .sat_o(sat)
  );

  sp_clamp #(.SP_W(SP_W)) u_clamp (
    .run_i(!stopped), .req_i(req_sp_i), .ramp_i(ramp_q), .sp_o
  );

  assign pulse_en_o = !stopped;
endmodule

// File: rtl/skip_ss_ctrl_chk.sv
module skip_ss_ctrl_chk #(
  parameter int unsigned SP_W  = 8,
  parameter int unsigned ENTER = 51,
  parameter int unsigned EXIT  = 63
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [SP_W-1:0] req_sp_i,
  input logic            restart_i,
  input logic            pulse_en_o,
  input logic [SP_W-1:0] sp_o,
  input logic [SP_W-1:0] ramp_i
);
  localparam logic [SP_W-1:0] ENTER_V = SP_W'(ENTER);
  localparam logic [SP_W-1:0] EXIT_V  = SP_W'(EXIT);

  AST_SKIP_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_en_o && req_sp_i <= ENTER_V) |=> !pulse_en_o); // R2
  AST_RUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_en_o && req_sp_i > ENTER_V) |=> pulse_en_o); // R2
  AST_SKIP_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_en_o && req_sp_i >= EXIT_V) |=> pulse_en_o); // R3
  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_en_o && req_sp_i < EXIT_V) |=> !pulse_en_o); // R3
  AST_STOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_en_o |-> (sp_o == '0)); // R4
  AST_SP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_o <= req_sp_i) && (sp_o <= ramp_i)); // R5
  AST_RAMP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_i != $past(ramp_i)) |-> (ramp_i == '0 || ramp_i == $past(ramp_i) + 1'b1)); // R7
  AST_RESTART_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (ramp_i == '0)); // R8
  AST_RAMP_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&ramp_i && pulse_en_o && !restart_i) |=> (&ramp_i || !pulse_en_o)); // R9
endmodule

bind skip_ss_ctrl skip_ss_ctrl_chk #(.SP_W(SP_W), .ENTER(ENTER_CODE), .EXIT(EXIT_CODE)) u_chk (
  .clk_i, .rst_ni, .req_sp_i, .restart_i, .pulse_en_o, .sp_o, .ramp_i(ramp_q)
);

// File: tb/skip_ss_ctrl_test.sv
`timescale 1ns/1ps
module skip_ss_ctrl_test;
  localparam int SP_W = 6, COLD = 5, WARM = 2;
  localparam int FULL = 63, ENTER = 12, EXIT = 15;

  logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0;
  logic [SP_W-1:0] req = '0;
  logic pulse_en;
  logic [SP_W-1:0] sp;
  int n_chk = 0, n_fail = 0;
  bit exp_run;

  always #5 clk = ~clk;

  skip_ss_ctrl #(.SP_W(SP_W), .COLD_DIV(COLD), .WARM_DIV(WARM)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_sp_i(req), .restart_i(restart),
    .pulse_en_o(pulse_en), .sp_o(sp)
  );

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic enter_stop();
    req = '0; step(); step();
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    req = SP_W'(FULL);
    #23;
    chk("R1 pulse_en in reset", pulse_en, 1);
    chk("R1 sp in reset", sp, 0);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 sp after release", sp, 0);
    // R6 cold ramp after reset
    for (int n = 1; n <= FULL*COLD + 10; n++) begin
      step();
      chk("R6 cold ramp", sp, min2(FULL, n / COLD));
    end
    // R5 / R9 pass-through at full ramp
    for (int v = ENTER + 1; v <= FULL; v++) begin
      req = SP_W'(v); #1;
      chk("R9 pass-through", sp, v);
    end
    step();
    chk("R9 ramp held at full", sp, FULL);
    // R2/R3 hysteresis sweep down then up
    exp_run = 1'b1;
    for (int v = FULL; v >= 0; v--) begin
      req = SP_W'(v); step();
      if (exp_run && v <= ENTER) exp_run = 1'b0;
      chk("R2 falling sweep", pulse_en, int'(exp_run));
      if (!exp_run) chk("R4 sp zero when stopped", sp, 0);
    end
    for (int v = 0; v <= FULL; v++) begin
      req = SP_W'(v); step();
      if (!exp_run && v >= EXIT) exp_run = 1'b1;
      chk("R3 rising sweep", pulse_en, int'(exp_run));
    end
    // R3 hold just below exit
    enter_stop();
    req = SP_W'(EXIT - 1);
    for (int i = 0; i < 6; i++) begin
      step(); chk("R3 hold below exit", pulse_en, 0);
      chk("R4 sp zero", sp, 0);
    end
    // R2 hold just above enter
    req = SP_W'(FULL); step();
    req = SP_W'(ENTER + 1);
    for (int i = 0; i < 6; i++) begin
      step(); chk("R2 hold above enter", pulse_en, 1);
    end
    // R7 warm ramp after skip resume
    enter_stop();
    req = SP_W'(FULL);
    for (int j = 1; j <= FULL*WARM + 6; j++) begin
      step(); chk("R7 warm ramp", sp, min2(FULL, (j - 1) / WARM));
    end
    // R5 clamp by request mid-ramp
    enter_stop();
    req = 6'd40;
    for (int j = 1; j <= 100; j++) begin
      step(); chk("R5 clamp", sp, min2(40, (j - 1) / WARM));
    end
    req = SP_W'(FULL);
    for (int i = 0; i < 60; i++) step();
    chk("R9 full again", sp, FULL);
    // R8 restart while running
    restart = 1'b1; step(); restart = 1'b0; #1;
    chk("R8 restart clears", sp, 0);
    for (int k = 1; k <= FULL*COLD + 6; k++) begin
      step(); chk("R8 cold after restart", sp, min2(FULL, k / COLD));
    end
    // R8 restart inside stop period
    enter_stop();
    restart = 1'b1; step(); restart = 1'b0;
    req = SP_W'(FULL);
    for (int j = 1; j <= 60; j++) begin
      step(); chk("R8 cold after stop restart", sp, min2(FULL, (j - 1) / COLD));
    end
    // R8 restart coincident with stop entry
    for (int i = 0; i < 300; i++) step();
    req = '0; restart = 1'b1; step(); restart = 1'b0;
    chk("R2 stop with restart", pulse_en, 0);
    step();
    req = SP_W'(FULL);
    for (int j = 1; j <= 60; j++) begin
      step(); chk("R8 coincident cold ramp", sp, min2(FULL, (j - 1) / COLD));
    end
    finish_run();
  end
endmodule